// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Non-Maskable Line

This block arbitrates interrupt requests for a small processor core. It keeps a register of pending lines and a register of enabled lines. Each line has a fixed priority level and a fixed kind, both chosen when the design is elaborated. The kinds are: level-sensitive, edge-triggered, software-raised, or non-maskable. On every cycle the block looks for the highest priority level that holds a pending line it may deliver. A level qualifies only if it lies above the core's effective current level. The block then raises a request carrying that level.

When the core answers with a one-cycle accept strobe, the block updates its status register. It writes the level field and the exception-mode flag, and for level 1 it also writes the cause code. It also latches the taken level and the vector index. Software reaches the pending, enable and status registers through a single write port with an operation code.

A single non-maskable level sits one step above every maskable level. A pending line of that kind is always delivered: the enable bits, the current level and exception mode do not block it. Its pending bit drops by itself when it is taken.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held and right after it, the pending bits, enable bits, status level, exception-mode flag, cause, taken level and vector index are all zero, and `irq_req` is low.
- R2: A level-kind line's pending bit copies its `irq_in` bit one clock later. An edge-kind or non-maskable line's pending bit is set one clock after its input goes from 0 to 1, and then stays set after the input falls.
- R3: The write port's `reg_op` values work as follows:
  - 0 sets pending bits for software-kind lines only.
  - 1 clears pending bits for software-kind and edge-kind lines only; level-kind and non-maskable bits are not affected.
  - 2 loads the enable register from `reg_wdata`.
  - 3 loads the status register: `reg_wdata[LW-1:0]` goes to the level field and `reg_wdata[LW]` to exception mode.
- R4: If a hardware edge sets a line's pending bit in the same cycle that a clear operation names it, the bit ends up set.
- R5: Only pending lines that are enabled, or are non-maskable, can raise `irq_req`.
- R6: The effective current level is computed in two steps:
  - Take the status level. If exception mode is set, raise it to at least `EXCM_LEVEL` (default 1).
  - Cap the result at `NMI_LVL-1`.
  A level raises a request only if it is above the effective current level.
- R7: `req_level` is the highest level that holds a line able to raise a request, and `irq_req` is high exactly when such a level exists.
- R8: A pending non-maskable line drives `req_level` to `NMI_LVL` (default 4) whatever the enable register, the status level (even at or above `NMI_LVL`) or exception mode hold.
- R9: An accept taken at level L > 1 does the following, all visible after the next clock edge:
  - The status level becomes L and exception mode is set.
  - `taken_level` becomes L and `vec_idx` becomes L.
- R10: An accept taken at level 1 does the following:
  - `cause` is loaded with `L1_CAUSE` (default 4) and exception mode is set.
  - The status level is unchanged.
  - `taken_level` becomes 1 and `vec_idx` becomes 0.
- R11: Taking the non-maskable level clears its pending bit, unless a new rising edge arrives in that same cycle.
- R12: An accept while `irq_req` is low changes neither the status register nor the taken level, the vector index or the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N | Hardware interrupt inputs, one per line |
| reg_we | input | 1 | Write strobe for the register port |
| reg_op | input | 2 | Write operation: 0 set, 1 clear, 2 enable, 3 status |
| reg_wdata | input | N | Write data |
| accept | input | 1 | Core accepts the requested interrupt (one-cycle strobe) |
| irq_req | output | 1 | An interrupt is eligible for delivery |
| req_level | output | LW | Level of the eligible interrupt |
| ps_level | output | LW | Status register level field |
| ps_excm | output | 1 | Status register exception-mode flag |
| cause | output | CW | Cause register |
| taken_level | output | LW | Level of the last taken interrupt |
| vec_idx | output | LW | Vector index of the last taken interrupt |

## Verification
A change on `irq_in` reaches the pending register at the next rising edge. From there, `irq_req` and `req_level` follow without further delay, so the request is due one edge after the input change. A register write or an accept also takes effect on the single edge where its strobe is high, and so do the request outputs that depend on it. The bench changes every input at a falling edge and reads every result at the following falling edge, which is exactly one rising edge later. No check samples a result before the edge that produces it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   // kind of each interrupt line, two bits per line in LINE_TYPE
   typedef enum logic [1:0] {
      LK_LEVEL = 2'd0,
      LK_EDGE  = 2'd1,
      LK_SOFT  = 2'd2,
      LK_NMI   = 2'd3
   } line_kind_e;

   // operation codes on the register write port
   typedef enum logic [1:0] {
      WOP_SET  = 2'd0,
      WOP_CLR  = 2'd1,
      WOP_EN   = 2'd2,
      WOP_STAT = 2'd3
   } wr_op_e;

   // width of one per-line level field in LINE_LEVEL
   localparam int LVL_FLD = 4;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
   import irq_prio_pkg::*;
#(
   parameter int N = 8,
   parameter logic [2*N-1:0] LINE_TYPE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] sw_set,
   input  logic [N-1:0] sw_clr,
   input  logic         nmi_ack,
   output logic [N-1:0] pend_q
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= irq_in;
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      localparam logic [1:0] KIND   = LINE_TYPE[2*i +: 2];
      localparam logic       IS_LVL = (KIND == LK_LEVEL);
      localparam logic       SET_OK = (KIND == LK_SOFT);
      localparam logic       CLR_OK = (KIND == LK_SOFT) || (KIND == LK_EDGE);
      localparam logic       RISE_OK = (KIND == LK_EDGE) || (KIND == LK_NMI);
      localparam logic       IS_NMI = (KIND == LK_NMI);
      logic rise;
      logic held;

      assign rise = irq_in[i] & ~prev_q[i];
      assign held = pend_q[i] & ~(sw_clr[i] & CLR_OK) & ~(nmi_ack & IS_NMI);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend_q[i] <= 1'b0;
         else if (IS_LVL) pend_q[i] <= irq_in[i];
         else             pend_q[i] <= held | (sw_set[i] & SET_OK) | (rise & RISE_OK);
      end
   end
endmodule

// File: rtl/irq_lvl_search.sv
module irq_lvl_search
   import irq_prio_pkg::*;
#(
   parameter int N          = 8,
   parameter int LW         = 3,
   parameter int NLVL       = 4,
   parameter int NMI_LVL    = 4,
   parameter int EXCM_LEVEL = 1,
   parameter logic [N*LVL_FLD-1:0] LINE_LEVEL = '0
) (
   input  logic [N-1:0]  pend,
   input  logic [N-1:0]  enable,
   input  logic [N-1:0]  nmi_lines,
   input  logic [LW-1:0] ps_level,
   input  logic          ps_excm,
   output logic          irq_req,
   output logic [LW-1:0] req_level
);
   logic [N-1:0]  lvl_mask [1:NLVL];
   logic [N-1:0]  cand;
   logic [LW-1:0] cur_raw;
   logic [LW-1:0] cur_eff;

   for (genvar l = 1; l <= NLVL; l++) begin : g_lvl
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign lvl_mask[l][i] = (int'(LINE_LEVEL[LVL_FLD*i +: LVL_FLD]) == l);
      end
   end

   assign cand    = pend & (enable | nmi_lines);
   assign cur_raw = (ps_excm && int'(ps_level) < EXCM_LEVEL) ? LW'(EXCM_LEVEL) : ps_level;
   assign cur_eff = (int'(cur_raw) >= NMI_LVL) ? LW'(NMI_LVL - 1) : cur_raw;

   always_comb begin
      irq_req   = 1'b0;
      req_level = '0;
      for (int l = NLVL; l >= 1; l--) begin
         if (!irq_req && l > int'(cur_eff) && |(lvl_mask[l] & cand)) begin
            irq_req   = 1'b1;
            req_level = LW'(l);
         end
      end
   end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int LW       = 3,
   parameter int CW       = 6,
   parameter int L1_CAUSE = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stat_we,
   input  logic [LW:0]   stat_data,
   input  logic          take,
   input  logic [LW-1:0] take_level,
   output logic [LW-1:0] ps_level,
   output logic          ps_excm,
   output logic [CW-1:0] cause,
   output logic [LW-1:0] taken_level,
   output logic [LW-1:0] vec_idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_level    <= '0;
         ps_excm     <= 1'b0;
         cause       <= '0;
         taken_level <= '0;
         vec_idx     <= '0;
      end else if (take) begin
         ps_excm     <= 1'b1;
         taken_level <= take_level;
         if (take_level > LW'(1)) begin
            ps_level <= take_level;
            vec_idx  <= take_level;
         end else begin
            cause   <= CW'(L1_CAUSE);
            vec_idx <= '0;
         end
      end else if (stat_we) begin
         ps_level <= stat_data[LW-1:0];
         ps_excm  <= stat_data[LW];
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int N               = 8,
   parameter int NUM_MASK_LEVELS = 3,
   parameter bit HAS_NMI         = 1'b1,
   parameter int NMI_LVL         = NUM_MASK_LEVELS + 1,
   parameter int EXCM_LEVEL      = 1,
   parameter int CW              = 6,
   parameter int L1_CAUSE        = 4,
   parameter logic [N*LVL_FLD-1:0] LINE_LEVEL =
      {4'd4, 4'd1, 4'd3, 4'd3, 4'd2, 4'd2, 4'd1, 4'd1},
   parameter logic [2*N-1:0] LINE_TYPE =
      {2'd3, 2'd0, 2'd0, 2'd2, 2'd1, 2'd0, 2'd2, 2'd1},
   localparam int LW   = $clog2(NUM_MASK_LEVELS + 2),
   localparam int NLVL = NUM_MASK_LEVELS + (HAS_NMI ? 1 : 0)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  irq_in,
   input  logic          reg_we,
   input  logic [1:0]    reg_op,
   input  logic [N-1:0]  reg_wdata,
   input  logic          accept,
   output logic          irq_req,
   output logic [LW-1:0] req_level,
   output logic [LW-1:0] ps_level,
   output logic          ps_excm,
   output logic [CW-1:0] cause,
   output logic [LW-1:0] taken_level,
   output logic [LW-1:0] vec_idx
);
   // elaboration-time parameter checks
   if (N < 1 || N > 32) begin : g_bad_n
      $error("irq_prio_ctrl: N must be 1..32");
   end
   if (NMI_LVL != NUM_MASK_LEVELS + 1) begin : g_bad_nmi
      $error("irq_prio_ctrl: NMI_LVL must sit one above the maskable levels");
   end
   if (N < LW + 1) begin : g_bad_wdata
      $error("irq_prio_ctrl: write data too narrow for the status fields");
   end
   if (EXCM_LEVEL < 0 || EXCM_LEVEL > NUM_MASK_LEVELS) begin : g_bad_excm
      $error("irq_prio_ctrl: EXCM_LEVEL out of range");
   end

   logic [N-1:0] nmi_lines;
   logic [N-1:0] pend_q;
   logic [N-1:0] enable_q;
   logic [N-1:0] sw_set;
   logic [N-1:0] sw_clr;
   logic         take;
   logic         nmi_ack;

   for (genvar i = 0; i < N; i++) begin : g_cfg
      localparam logic [1:0] KIND = LINE_TYPE[2*i +: 2];
      localparam int         LVL  = int'(LINE_LEVEL[LVL_FLD*i +: LVL_FLD]);
      if (KIND == LK_NMI && (!HAS_NMI || LVL != NMI_LVL)) begin : g_bad_nmi_line
         $error("irq_prio_ctrl: non-maskable line misconfigured");
      end
      if (KIND != LK_NMI && (LVL < 1 || LVL > NUM_MASK_LEVELS)) begin : g_bad_lvl
         $error("irq_prio_ctrl: maskable line level out of range");
      end
      assign nmi_lines[i] = (KIND == LK_NMI);
   end

   assign sw_set = (reg_we && reg_op == WOP_SET) ? reg_wdata : '0;
   assign sw_clr = (reg_we && reg_op == WOP_CLR) ? reg_wdata : '0;
   assign take   = accept & irq_req;

   if (HAS_NMI) begin : g_nmi_ack
      assign nmi_ack = take && (int'(req_level) == NMI_LVL);
   end else begin : g_no_nmi_ack
      assign nmi_ack = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          enable_q <= '0;
      else if (reg_we && reg_op == WOP_EN) enable_q <= reg_wdata;
   end

   irq_pend_reg #(.N(N), .LINE_TYPE(LINE_TYPE)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .sw_set  (sw_set),
      .sw_clr  (sw_clr),
      .nmi_ack (nmi_ack),
      .pend_q  (pend_q)
   );

   irq_lvl_search #(
      .N(N), .LW(LW), .NLVL(NLVL), .NMI_LVL(NMI_LVL),
      .EXCM_LEVEL(EXCM_LEVEL), .LINE_LEVEL(LINE_LEVEL)
   ) u_search (
      .pend      (pend_q),
      .enable    (enable_q),
      .nmi_lines (nmi_lines),
      .ps_level  (ps_level),
      .ps_excm   (ps_excm),
      .irq_req   (irq_req),
      .req_level (req_level)
   );

   irq_status_reg #(.LW(LW), .CW(CW), .L1_CAUSE(L1_CAUSE)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .stat_we     (reg_we && reg_op == WOP_STAT),
      .stat_data   (reg_wdata[LW:0]),
      .take        (take),
      .take_level  (req_level),
      .ps_level    (ps_level),
      .ps_excm     (ps_excm),
      .cause       (cause),
      .taken_level (taken_level),
      .vec_idx     (vec_idx)
   );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int N        = 8,
   parameter int LW       = 3,
   parameter int CW       = 6,
   parameter int NMI_LVL  = 4,
   parameter int L1_CAUSE = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  irq_in,
   input logic          accept,
   input logic [N-1:0]  pend_q,
   input logic [N-1:0]  enable_q,
   input logic [N-1:0]  nmi_lines,
   input logic          irq_req,
   input logic [LW-1:0] req_level,
   input logic [LW-1:0] ps_level,
   input logic          ps_excm,
   input logic [CW-1:0] cause,
   input logic [LW-1:0] taken_level,
   input logic [LW-1:0] vec_idx
);
   AST_NO_ELIGIBLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & (enable_q | nmi_lines)) == '0) |-> !irq_req); // R5

   AST_MASKABLE_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && int'(req_level) != NMI_LVL) |-> (req_level > ps_level)); // R6

   AST_NMI_ALWAYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & nmi_lines) != '0) |-> (irq_req && int'(req_level) == NMI_LVL)); // R8

   AST_TAKE_HIGH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && irq_req && req_level > LW'(1)) |=>
      (ps_level == $past(req_level) && ps_excm && vec_idx == $past(req_level)
       && taken_level == $past(req_level))); // R9

   AST_TAKE_LEVEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && irq_req && req_level == LW'(1)) |=>
      (cause == CW'(L1_CAUSE) && ps_excm && vec_idx == '0 && $stable(ps_level))); // R10

   AST_NMI_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && irq_req && int'(req_level) == NMI_LVL && (irq_in & nmi_lines) == '0) |=>
      ((pend_q & nmi_lines) == '0)); // R11

   AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !irq_req) |=> ($stable(taken_level) && $stable(vec_idx) && $stable(cause))); // R12
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .N(N), .LW(LW), .CW(CW), .NMI_LVL(NMI_LVL), .L1_CAUSE(L1_CAUSE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_in      (irq_in),
   .accept      (accept),
   .pend_q      (pend_q),
   .enable_q    (enable_q),
   .nmi_lines   (nmi_lines),
   .irq_req     (irq_req),
   .req_level   (req_level),
   .ps_level    (ps_level),
   .ps_excm     (ps_excm),
   .cause       (cause),
   .taken_level (taken_level),
   .vec_idx     (vec_idx)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
   localparam int CLK_P = 10;
   localparam int N     = 8;
   localparam int LW    = 3;
   localparam int CW    = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_op = '0;
   logic [N-1:0]  reg_wdata = '0;
   logic          accept = 1'b0;
   logic          irq_req;
   logic [LW-1:0] req_level;
   logic [LW-1:0] ps_level;
   logic          ps_excm;
   logic [CW-1:0] cause;
   logic [LW-1:0] taken_level;
   logic [LW-1:0] vec_idx;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_prio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
      .reg_op(reg_op), .reg_wdata(reg_wdata), .accept(accept),
      .irq_req(irq_req), .req_level(req_level), .ps_level(ps_level),
      .ps_excm(ps_excm), .cause(cause), .taken_level(taken_level),
      .vec_idx(vec_idx)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] op, input logic [N-1:0] data);
      reg_we = 1'b1; reg_op = op; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic take();
      accept = 1'b1;
      @(negedge clk);
      accept = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "irq_req", 32'(irq_req), 0);
      chk("R1", "ps_level", 32'(ps_level), 0);
      chk("R1", "ps_excm", 32'(ps_excm), 0);
      chk("R1", "cause", 32'(cause), 0);
      chk("R1", "taken_level", 32'(taken_level), 0);
      chk("R1", "vec_idx", 32'(vec_idx), 0);
   endtask

   task automatic t_level_enable();
      irq_in[2] = 1'b1; step();
      chk("R5", "disabled level line", 32'(irq_req), 0);
      wr(2'd2, 8'hFF);
      chk("R7", "enabled level line req", 32'(irq_req), 1);
      chk("R7", "enabled level line lvl", 32'(req_level), 2);
      irq_in[2] = 1'b0; step();
      chk("R2", "level line follows input", 32'(irq_req), 0);
   endtask

   task automatic t_edge();
      irq_in[3] = 1'b1; step();
      chk("R2", "edge line set", 32'({irq_req, req_level}), 32'({1'b1, 3'd2}));
      irq_in[3] = 1'b0; step();
      chk("R2", "edge line held", 32'({irq_req, req_level}), 32'({1'b1, 3'd2}));
      irq_in[2] = 1'b1; step();
      wr(2'd1, 8'h0C);
      chk("R3", "clear spares level line", 32'({irq_req, req_level}), 32'({1'b1, 3'd2}));
      irq_in[2] = 1'b0; step();
      chk("R3", "edge line cleared", 32'(irq_req), 0);
   endtask

   task automatic t_soft();
      wr(2'd0, 8'h17);
      chk("R3", "set reaches soft lines", 32'({irq_req, req_level}), 32'({1'b1, 3'd3}));
      wr(2'd1, 8'h10);
      chk("R3", "clear soft lvl3", 32'({irq_req, req_level}), 32'({1'b1, 3'd1}));
      wr(2'd1, 8'h02);
      chk("R3", "set ignored edge line", 32'(irq_req), 0);
   endtask

   task automatic t_set_wins();
      irq_in[0] = 1'b1;
      wr(2'd1, 8'h01);
      chk("R4", "edge beats clear", 32'({irq_req, req_level}), 32'({1'b1, 3'd1}));
      wr(2'd1, 8'h01);
      chk("R4", "clear without edge", 32'(irq_req), 0);
      irq_in[0] = 1'b0; step();
   endtask

   task automatic t_level_gate();
      wr(2'd0, 8'h12);
      chk("R7", "highest of two", 32'({irq_req, req_level}), 32'({1'b1, 3'd3}));
      wr(2'd3, 8'h03);
      chk("R6", "cur level 3 blocks", 32'(irq_req), 0);
      wr(2'd3, 8'h02);
      chk("R6", "cur level 2 admits 3", 32'({irq_req, req_level}), 32'({1'b1, 3'd3}));
      wr(2'd3, 8'h08);
      wr(2'd1, 8'h10);
      chk("R6", "excm blocks level 1", 32'(irq_req), 0);
      wr(2'd3, 8'h00);
      chk("R6", "level 1 admitted", 32'({irq_req, req_level}), 32'({1'b1, 3'd1}));
   endtask

   task automatic t_accept();
      take();
      chk("R10", "cause", 32'(cause), 4);
      chk("R10", "excm", 32'(ps_excm), 1);
      chk("R10", "level kept", 32'(ps_level), 0);
      chk("R10", "taken/vec", 32'({taken_level, vec_idx}), 32'({3'd1, 3'd0}));
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h10);
      take();
      chk("R9", "status", 32'({ps_excm, ps_level}), 32'({1'b1, 3'd3}));
      chk("R9", "taken/vec", 32'({taken_level, vec_idx}), 32'({3'd3, 3'd3}));
      chk("R12", "no request", 32'(irq_req), 0);
      take();
      chk("R12", "idle accept taken/vec", 32'({taken_level, vec_idx}), 32'({3'd3, 3'd3}));
      chk("R12", "idle accept status", 32'({ps_excm, ps_level, cause}), 32'({1'b1, 3'd3, 6'd4}));
      wr(2'd1, 8'h12);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_nmi();
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h0F);
      irq_in[7] = 1'b1; step();
      chk("R8", "nmi despite mask/level/excm", 32'({irq_req, req_level}), 32'({1'b1, 3'd4}));
      take();
      chk("R9", "nmi status", 32'({ps_excm, ps_level}), 32'({1'b1, 3'd4}));
      chk("R9", "nmi taken/vec", 32'({taken_level, vec_idx}), 32'({3'd4, 3'd4}));
      chk("R11", "nmi self-clear", 32'(irq_req), 0);
      irq_in[7] = 1'b0; step();
      irq_in[7] = 1'b1; step();
      chk("R8", "nmi at cur level 4", 32'({irq_req, req_level}), 32'({1'b1, 3'd4}));
      wr(2'd1, 8'h80);
      chk("R3", "clear spares nmi", 32'({irq_req, req_level}), 32'({1'b1, 3'd4}));
      take();
      chk("R11", "nmi cleared again", 32'(irq_req), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_level_enable();
      t_edge();
      t_soft();
      t_set_wins();
      t_level_gate();
      t_accept();
      t_nmi();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule